// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer

A down-counting timer that works in one of three ways. In waveform mode it runs freely and swaps between two reload values at every underflow, so a pin toggles with a programmable high time and low time. In event mode the same pin becomes an input, and its rising edges clock the counter. In capture mode the counter runs on the system clock. The two reload registers then record the counter value when edges arrive on two input pins. Each capture raises its own pending flag.

Software drives the block through one write port. A 2-bit select picks the control register, either reload register, or the counter itself. All state is visible on plain output pins. Both pending flags stay set until a clear input removes them. The block carries no data stream, so every pin is a plain control or status signal, with no valid/ready handshake and no back-pressure.

Top module: `tmr16_multimode`

## Requirements
- R1: While reset is asserted, and right after it, the counter, both reload registers, both pending flags, `tio_out` and `tio_oe` read zero. The mode is idle (code 0) and the run bit is clear.
- R2: A cycle with `wr_en` high loads `wr_data` at the next clock edge into one target, chosen by `wr_sel`: 0 is control, 1 is reload A, 2 is reload B, 3 is the counter. A write to the counter or to a reload register wins over any timer action in that cycle. The control fields are bits 2:0 mode, bit 3 run, bit 4 capture-A polarity and bit 5 capture-B polarity.
- R3: In waveform mode (code 1) with run set, the counter decrements once per clock. When it reads zero, `tio_out` toggles at the next edge. The counter then loads reload A if `tio_out` becomes 1, or reload B if it becomes 0, and pending A is set. `tio_oe` is high only in this mode.
- R4: In event mode (code 2) with run set, `tio_oe` is low. Each rising edge seen on `tio_in` decrements the counter. An edge that finds the counter at zero loads reload A instead and sets pending A.
- R5: In waveform or event mode with run clear, the counter and `tio_out` hold their values.
- R6: In capture mode (code 3), the counter decrements every clock whatever the run bit says. From zero it wraps to all ones and sets pending B.
- R7: In capture mode, an edge on `tio_in` copies the counter into reload A and sets pending A. An edge on `capb_in` copies the counter into reload B and sets pending B. For each input, a polarity bit of 0 selects rising edges and 1 selects falling edges.
- R8: A pin level first sampled at clock edge k acts at edge k+2. A capture stores the counter value held just before edge k+2.
- R9: A pending flag stays set until its clear input is high. A set condition in the same cycle as a clear wins.
- R10: Mode codes 0 and 4 through 7 leave the counter, output and flags unchanged, apart from register writes and clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 reload A, 2 reload B, 3 counter |
| wr_data | input | 16 | Write data |
| clr_a | input | 1 | Clear pending A |
| clr_b | input | 1 | Clear pending B |
| tio_in | input | 1 | Shared pin, input side: event clock or capture A |
| capb_in | input | 1 | Capture B input |
| tio_out | output | 1 | Waveform output |
| tio_oe | output | 1 | Drive enable for the shared pin |
| cnt_o | output | 16 | Counter value |
| rld_a_o | output | 16 | Reload/capture register A |
| rld_b_o | output | 16 | Reload/capture register B |
| pend_a | output | 1 | Pending flag A |
| pend_b | output | 1 | Pending flag B |

## Verification
Register writes, underflow reloads, waveform toggles and flag changes show up on the outputs one clock after the cycle that causes them. A pin edge acts two edges after its first sample. The bench model steps at each rising edge, taking its inputs from the same cycle, and keeps a short history of pin samples so that every edge acts with exactly that two-edge delay. All outputs are compared with the model at each falling edge, half a period after the design has settled and before new inputs are driven.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam logic [2:0] MODE_IDLE = 3'd0;
  localparam logic [2:0] MODE_PWM  = 3'd1;
  localparam logic [2:0] MODE_EVT  = 3'd2;
  localparam logic [2:0] MODE_CAP  = 3'd3;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_RLA  = 2'd1;
  localparam logic [1:0] SEL_RLB  = 2'd2;
  localparam logic [1:0] SEL_CNT  = 2'd3;

  localparam int CTRL_RUN_BIT  = 3;
  localparam int CTRL_POLA_BIT = 4;
  localparam int CTRL_POLB_BIT = 5;
endpackage

// File: rtl/tmr16_edge.sv
module tmr16_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs
  import tmr16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         cap_a,
  input  logic         cap_b,
  input  logic [W-1:0] cnt,
  output logic [2:0]   mode,
  output logic         run,
  output logic         pol_a,
  output logic         pol_b,
  output logic [W-1:0] rld_a,
  output logic [W-1:0] rld_b
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= MODE_IDLE;
      run   <= 1'b0;
      pol_a <= 1'b0;
      pol_b <= 1'b0;
    end else if (wr_en && wr_sel == SEL_CTRL) begin
      mode  <= wr_data[2:0];
      run   <= wr_data[CTRL_RUN_BIT];
      pol_a <= wr_data[CTRL_POLA_BIT];
      pol_b <= wr_data[CTRL_POLB_BIT];
    end
  end

  // software write has priority over a capture in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_a <= '0;
      rld_b <= '0;
    end else begin
      if (wr_en && wr_sel == SEL_RLA) rld_a <= wr_data;
      else if (cap_a)                 rld_a <= cnt;
      if (wr_en && wr_sel == SEL_RLB) rld_b <= wr_data;
      else if (cap_b)                 rld_b <= cnt;
    end
  end
endmodule

// File: rtl/tmr16_count.sv
module tmr16_count
  import tmr16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   mode,
  input  logic         run,
  input  logic         evt_edge,
  input  logic         wr_cnt,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] rld_a,
  input  logic [W-1:0] rld_b,
  output logic [W-1:0] cnt,
  output logic         pwm_out,
  output logic         underflow
);
  logic [W-1:0] cnt_d;
  logic         out_d;
  logic         zero;

  assign zero = (cnt == '0);

  always_comb begin
    cnt_d     = cnt;
    out_d     = pwm_out;
    underflow = 1'b0;
    case (mode)
      MODE_PWM: if (run) begin
        if (zero) begin
          underflow = 1'b1;
          out_d     = ~pwm_out;
          cnt_d     = pwm_out ? rld_b : rld_a;
        end else begin
          cnt_d = cnt - 1'b1;
        end
      end
      MODE_EVT: if (run && evt_edge) begin
        if (zero) begin
          underflow = 1'b1;
          cnt_d     = rld_a;
        end else begin
          cnt_d = cnt - 1'b1;
        end
      end
      MODE_CAP: begin
        underflow = zero;
        cnt_d     = cnt - 1'b1;
      end
      default: ;
    endcase
    if (wr_cnt) cnt_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pwm_out <= 1'b0;
    end else begin
      cnt     <= cnt_d;
      pwm_out <= out_d;
    end
  end
endmodule

// File: rtl/tmr16_flags.sv
module tmr16_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend[i] <= 1'b0;
      else if (set[i]) pend[i] <= 1'b1;
      else if (clr[i]) pend[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr16_multimode.sv
module tmr16_multimode
  import tmr16_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         clr_a,
  input  logic         clr_b,
  input  logic         tio_in,
  input  logic         capb_in,
  output logic         tio_out,
  output logic         tio_oe,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] rld_a_o,
  output logic [W-1:0] rld_b_o,
  output logic         pend_a,
  output logic         pend_b
);
  localparam int NPIN = 2;

  logic [NPIN-1:0] pin_raw, pin_rise, pin_fall;
  logic [2:0]      mode_q;
  logic            run_q, pol_a, pol_b;
  logic            cap_a, cap_b, uf;
  logic [W-1:0]    cnt_q, rld_a, rld_b;
  logic [1:0]      flag_set, flag_pend;

  assign pin_raw = {capb_in, tio_in};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    tmr16_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_raw[g]),
      .rise (pin_rise[g]),
      .fall (pin_fall[g])
    );
  end

  assign cap_a = (mode_q == MODE_CAP) && (pol_a ? pin_fall[0] : pin_rise[0]);
  assign cap_b = (mode_q == MODE_CAP) && (pol_b ? pin_fall[1] : pin_rise[1]);

  tmr16_regs #(.W(W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .cap_a  (cap_a),
    .cap_b  (cap_b),
    .cnt    (cnt_q),
    .mode   (mode_q),
    .run    (run_q),
    .pol_a  (pol_a),
    .pol_b  (pol_b),
    .rld_a  (rld_a),
    .rld_b  (rld_b)
  );

  tmr16_count #(.W(W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_q),
    .run      (run_q),
    .evt_edge (pin_rise[0]),
    .wr_cnt   (wr_en && wr_sel == SEL_CNT),
    .wr_data  (wr_data),
    .rld_a    (rld_a),
    .rld_b    (rld_b),
    .cnt      (cnt_q),
    .pwm_out  (tio_out),
    .underflow(uf)
  );

  // capture mode routes underflow to flag B, the counting modes to flag A
  assign flag_set[0] = cap_a | (uf && mode_q != MODE_CAP);
  assign flag_set[1] = cap_b | (uf && mode_q == MODE_CAP);

  tmr16_flags #(.N(2)) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (flag_set),
    .clr  ({clr_b, clr_a}),
    .pend (flag_pend)
  );

  assign pend_a  = flag_pend[0];
  assign pend_b  = flag_pend[1];
  assign tio_oe  = (mode_q == MODE_PWM);
  assign cnt_o   = cnt_q;
  assign rld_a_o = rld_a;
  assign rld_b_o = rld_b;
endmodule

// File: rtl/tmr16_checker.sv
module tmr16_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   mode,
  input logic         run,
  input logic         wr_en,
  input logic         clr_a,
  input logic [W-1:0] cnt,
  input logic [W-1:0] rld_a,
  input logic [W-1:0] rld_b,
  input logic         tio_out,
  input logic         pend_a,
  input logic         pend_b
);
  p_pwm_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && run && cnt == '0) |=> (tio_out != $past(tio_out)));

  p_pwm_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && run && cnt == '0 && !wr_en) |=> (cnt == (tio_out ? rld_a : rld_b)));

  p_hold_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd1 || mode == 3'd2) && !run && !wr_en) |=> ($stable(cnt) && $stable(tio_out)));

  p_cap_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && cnt == '0 && !wr_en) |=> (cnt == '1 && pend_b));

  p_sticky_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_a && !clr_a) |=> pend_a);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd0 || mode[2]) && !wr_en) |=> $stable(cnt));
endmodule

bind tmr16_multimode tmr16_checker #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .mode   (mode_q),
  .run    (run_q),
  .wr_en  (wr_en),
  .clr_a  (clr_a),
  .cnt    (cnt_q),
  .rld_a  (rld_a),
  .rld_b  (rld_b),
  .tio_out(tio_out),
  .pend_a (pend_a),
  .pend_b (pend_b)
);

// File: tb/test_tmr16_multimode.sv
module test_tmr16_multimode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        clr_a = 1'b0, clr_b = 1'b0;
  logic        tio_in = 1'b0, capb_in = 1'b0;
  logic        tio_out, tio_oe, pend_a, pend_b;
  logic [15:0] cnt_o, rld_a_o, rld_b_o;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  bit    started = 1'b0;
  string tag = "R1";

  always #10 clk = ~clk;

  tmr16_multimode i_tmr16_multimode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .clr_a(clr_a), .clr_b(clr_b), .tio_in(tio_in), .capb_in(capb_in),
    .tio_out(tio_out), .tio_oe(tio_oe), .cnt_o(cnt_o), .rld_a_o(rld_a_o),
    .rld_b_o(rld_b_o), .pend_a(pend_a), .pend_b(pend_b)
  );

  // behavioural reference
  logic [15:0] m_cnt, m_ra, m_rb;
  int          m_mode;
  bit          m_run, m_pa_pol, m_pb_pol, m_out, m_pa, m_pb;
  bit          hist_a[$], hist_b[$];

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      m_cnt = 0; m_ra = 0; m_rb = 0; m_mode = 0; m_run = 0;
      m_pa_pol = 0; m_pb_pol = 0; m_out = 0; m_pa = 0; m_pb = 0;
      hist_a = '{0, 0, 0}; hist_b = '{0, 0, 0};
    end else begin
      bit a_now, a_old, b_now, b_old, sa, sb, n_out;
      logic [15:0] n_cnt, n_ra, n_rb;
      a_now = hist_a[1]; a_old = hist_a[0];
      b_now = hist_b[1]; b_old = hist_b[0];
      n_cnt = m_cnt; n_ra = m_ra; n_rb = m_rb; n_out = m_out; sa = 0; sb = 0;
      if (m_mode == 1 && m_run) begin
        if (m_cnt == 0) begin
          n_out = !m_out; sa = 1;
          n_cnt = n_out ? m_ra : m_rb;
        end else n_cnt = m_cnt - 16'd1;
      end else if (m_mode == 2 && m_run && a_now && !a_old) begin
        if (m_cnt == 0) begin n_cnt = m_ra; sa = 1; end
        else n_cnt = m_cnt - 16'd1;
      end else if (m_mode == 3) begin
        if (m_cnt == 0) begin n_cnt = 16'hFFFF; sb = 1; end
        else n_cnt = m_cnt - 16'd1;
        if (m_pa_pol ? (a_old && !a_now) : (a_now && !a_old)) begin n_ra = m_cnt; sa = 1; end
        if (m_pb_pol ? (b_old && !b_now) : (b_now && !b_old)) begin n_rb = m_cnt; sb = 1; end
      end
      if (wr_en) begin
        case (wr_sel)
          2'd0: begin
            m_mode = int'(wr_data[2:0]); m_run = wr_data[3];
            m_pa_pol = wr_data[4]; m_pb_pol = wr_data[5];
          end
          2'd1: n_ra = wr_data;
          2'd2: n_rb = wr_data;
          default: n_cnt = wr_data;
        endcase
      end
      m_cnt = n_cnt; m_ra = n_ra; m_rb = n_rb; m_out = n_out;
      m_pa = sa || (m_pa && !clr_a);
      m_pb = sb || (m_pb && !clr_b);
      hist_a.push_back(tio_in); void'(hist_a.pop_front());
      hist_b.push_back(capb_in); void'(hist_b.pop_front());
    end
  end

  task automatic chk(input string nm, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", tag, nm, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("cnt_o",   cnt_o,   m_cnt);
      chk("rld_a_o", rld_a_o, m_ra);
      chk("rld_b_o", rld_b_o, m_rb);
      chk("tio_out", {15'd0, tio_out}, {15'd0, m_out});
      chk("tio_oe",  {15'd0, tio_oe},  {15'd0, (m_mode == 1)});
      chk("pend_a",  {15'd0, pend_a},  {15'd0, m_pa});
      chk("pend_b",  {15'd0, pend_b},  {15'd0, m_pb});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected finish before 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    tag = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(3);

    tag = "R2";
    wr(2'd1, 16'd3); wr(2'd2, 16'd5); wr(2'd3, 16'd7);
    idle(2);

    tag = "R10";
    idle(5);
    wr(2'd0, 16'h0005);
    idle(5);

    tag = "R3";
    wr(2'd3, 16'd2);
    wr(2'd0, 16'h0009);
    idle(40);

    tag = "R9";
    @(negedge clk); clr_a = 1'b1;
    idle(20);
    clr_a = 1'b0;
    idle(6);

    tag = "R5";
    wr(2'd0, 16'h0001);
    idle(8);

    tag = "R4";
    wr(2'd1, 16'd2); wr(2'd3, 16'd1);
    wr(2'd0, 16'h000A);
    for (int i = 0; i < 16; i++) begin
      tio_in = ~tio_in;
      idle(i % 4 + 1);
    end
    clr_a = 1'b1; idle(1); clr_a = 1'b0;
    wr(2'd0, 16'h0002);
    tio_in = ~tio_in; idle(3); tio_in = ~tio_in; idle(4);

    tag = "R6";
    tio_in = 1'b0;
    wr(2'd3, 16'd10);
    wr(2'd0, 16'h0013);
    idle(18);

    tag = "R7";
    for (int i = 0; i < 24; i++) begin
      if (i % 3 == 0) tio_in = ~tio_in;
      if (i % 5 == 1) capb_in = ~capb_in;
      idle(i % 3 + 1);
    end
    clr_b = 1'b1; idle(2); clr_b = 1'b0;
    wr(2'd0, 16'h0023);
    for (int i = 0; i < 10; i++) begin
      tio_in = ~tio_in; capb_in = ~capb_in;
      idle(2);
    end

    tag = "R8";
    capb_in = 1'b0; idle(4);
    capb_in = 1'b1; idle(1); capb_in = 1'b0;
    idle(6);
    tio_in = ~tio_in; idle(1);
    wr(2'd1, 16'hABCD);
    idle(4);

    tag = "R10";
    wr(2'd0, 16'h0006);
    tio_in = ~tio_in; capb_in = ~capb_in;
    idle(8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule